// File: doc/BRIEF.md
# Integer Horner Shift-Add Multiplier

This block forms the product of two unsigned integers with only left shifts and additions, and it has no array multiplier. It walks the set bits of the multiplier from the most significant one down to the least significant one. The accumulator starts out equal to the multiplicand. At each further set bit the accumulator moves left by the gap between that bit and the previous one, and then the multiplicand is added to it. After the last set bit, the accumulator moves left once more by the position of that bit.

The block costs one clock per set bit of the multiplier. A cheap constant-like multiplier, with few ones, therefore finishes quickly. The caller pulses `start` with both operands while the unit is idle and waits for the one-cycle `done` pulse. The product keeps only the low bits that fit its width. A sticky overflow flag reports any weight that was lost during the computation.

Top module: `horner_mul`

## Requirements
- R1: While reset is held and after it is released, `product` is 0, `overflow` is 0 and `done` is 0 until the first operation completes.
- R2: When `done` is high, `product` equals the low PW bits of the true product of the operands that were accepted.
- R3: When `done` is high, `overflow` is 1 exactly when the true product is 2^PW or larger.
- R4: `start` is accepted on a rising edge when no operation is in progress. For nonzero operands, `done` is high for one cycle after the k-th rising edge, counting the accepting edge as the first. Here k is the number of 1 bits in the multiplier.
- R5: If either operand is zero, `done` is high right after the accepting edge, with `product` 0 and `overflow` 0.
- R6: A `start` that arrives while an operation is in progress, including during its final cycle, is ignored. The running result and its timing are unchanged.
- R7: `product` and `overflow` change only on the edge that raises `done`, and they hold their value in between.
- R8: A multiplier with a single 1 bit at position p completes after the accepting edge with the multiplicand shifted left by p. `overflow` is set if any bit is shifted beyond PW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request to begin a multiplication |
| multiplicand | input | W | Unsigned value added at every set bit |
| multiplier | input | W | Unsigned value whose set bits are scanned |
| product | output | PW | Low PW bits of the last result |
| overflow | output | 1 | Last result exceeded PW bits |
| done | output | 1 | One-cycle pulse when a result is posted |

## Verification
On every cycle, the assertions compare the posted result and overflow flag against a reference product that is captured at acceptance. They also track, with a countdown, the cycle in which `done` is due. They check that `done` never shows during a run, that the outputs hold between completions, and that zero operands finish at once. The directed scenarios are needed for the rest. These include a `start` issued mid-run, a `start` issued in the final cycle of a run, and back-to-back operations. They also cover worked cases such as 23 x 77, full-range operands that overflow, and single-bit multipliers at both ends of the word.

// File: rtl/horner_mul_pkg.sv
package horner_mul_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } hm_state_t;
endpackage

// File: rtl/hm_lead_one.sv
// hm_lead_one: combinational locator of the highest set bit of a vector.
// Assumes: the caller handles an all-zero vector separately; idx is then 0.
module hm_lead_one #(
    parameter int W  = 16,
    localparam int SW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  vec,
    output logic [SW-1:0] idx
);
    // Later (higher) set bits override earlier ones, leaving the top index.
    always_comb begin
        idx = '0;
        for (int i = 0; i < W; i++) begin
            if (vec[i]) idx = SW'(i);
        end
    end
endmodule

// File: rtl/hm_shl_ovf.sv
// hm_shl_ovf: left shift of a PW-bit word that also reports lost weight.
// Assumes: shift amounts below 2*PW; any nonzero bit pushed past PW sets lost.
module hm_shl_ovf #(
    parameter int PW = 16,
    parameter int SW = 4
) (
    input  logic [PW-1:0] din,
    input  logic [SW-1:0] sh,
    output logic [PW-1:0] dout,
    output logic          lost
);
    logic [2*PW-1:0] wide;

    // Widen, shift, then split into kept and discarded halves.
    always_comb begin
        wide = {{PW{1'b0}}, din} << sh;
        dout = wide[PW-1:0];
        lost = |wide[2*PW-1:PW];
    end
endmodule

// File: rtl/horner_mul.sv
// horner_mul: sequential unsigned multiplier built from shifts and adds only.
// Scans multiplier set bits from MSB to LSB, one set bit per cycle; the last
// step folds in the trailing shift by the lowest set bit position.
// Assumes: PW >= W; start is only taken while idle; results are held until
// the next completion; overflow is sticky across the steps of one operation.
module horner_mul #(
    parameter int W  = 16,
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [W-1:0]  multiplicand,
    input  logic [W-1:0]  multiplier,
    output logic [PW-1:0] product,
    output logic          overflow,
    output logic          done
);
    import horner_mul_pkg::*;

    localparam int SW = (W > 1) ? $clog2(W) : 1;

    hm_state_t     state;
    logic          run;
    logic [PW-1:0] acc;
    logic [PW-1:0] x_r;
    logic [SW-1:0] pos;
    logic [W-1:0]  rem_mask;
    logic          ovf_run;
    logic [PW-1:0] prod_r;
    logic          ovf_r;
    logic          done_r;

    logic [W-1:0]  scan_in;
    logic [SW-1:0] lead_idx;
    logic [W-1:0]  rest;
    logic          last;
    logic [SW-1:0] gap;
    logic [PW-1:0] gap_val;
    logic          gap_lost;
    logic [PW:0]   sum_w;
    logic [PW-1:0] x_ext;
    logic [PW-1:0] tail_in;
    logic [PW-1:0] tail_val;
    logic          tail_lost;
    logic          step_ovf;
    logic          zero_op;

    assign run = (state == ST_RUN);

    // Select the bits still to scan and the next-step control values.
    always_comb begin
        x_ext    = PW'(multiplicand);
        zero_op  = (multiplicand == '0) || (multiplier == '0);
        scan_in  = run ? rem_mask : multiplier;
        rest     = scan_in & ~(W'(1) << lead_idx);
        last     = (rest == '0);
        gap      = pos - lead_idx;
    end

    hm_lead_one #(.W(W)) u_lead (
        .vec (scan_in),
        .idx (lead_idx)
    );

    hm_shl_ovf #(.PW(PW), .SW(SW)) u_gap (
        .din  (acc),
        .sh   (gap),
        .dout (gap_val),
        .lost (gap_lost)
    );

    // Add the multiplicand after the gap shift and feed the tail shifter.
    always_comb begin
        sum_w    = {1'b0, gap_val} + {1'b0, x_r};
        step_ovf = gap_lost | sum_w[PW];
        tail_in  = run ? sum_w[PW-1:0] : x_ext;
    end

    hm_shl_ovf #(.PW(PW), .SW(SW)) u_tail (
        .din  (tail_in),
        .sh   (lead_idx),
        .dout (tail_val),
        .lost (tail_lost)
    );

    // Sequencer: accept, step per set bit, post result and pulse done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            acc      <= '0;
            x_r      <= '0;
            pos      <= '0;
            rem_mask <= '0;
            ovf_run  <= 1'b0;
            prod_r   <= '0;
            ovf_r    <= 1'b0;
            done_r   <= 1'b0;
        end else begin
            done_r <= 1'b0;
            if (!run) begin
                if (start) begin
                    if (zero_op) begin
                        prod_r <= '0;
                        ovf_r  <= 1'b0;
                        done_r <= 1'b1;
                    end else if (last) begin
                        prod_r <= tail_val;
                        ovf_r  <= tail_lost;
                        done_r <= 1'b1;
                    end else begin
                        acc      <= x_ext;
                        x_r      <= x_ext;
                        pos      <= lead_idx;
                        rem_mask <= rest;
                        ovf_run  <= 1'b0;
                        state    <= ST_RUN;
                    end
                end
            end else begin
                if (last) begin
                    prod_r <= tail_val;
                    ovf_r  <= ovf_run | step_ovf | tail_lost;
                    done_r <= 1'b1;
                    state  <= ST_IDLE;
                end else begin
                    acc      <= sum_w[PW-1:0];
                    ovf_run  <= ovf_run | step_ovf;
                    pos      <= lead_idx;
                    rem_mask <= rest;
                end
            end
        end
    end

    assign product  = prod_r;
    assign overflow = ovf_r;
    assign done     = done_r;
endmodule

// File: rtl/hm_checker.sv
// hm_checker: protocol and result properties for horner_mul, bound below.
// Assumes: the run signal of the bound instance marks an operation in flight.
module hm_checker #(
    parameter int W  = 16,
    parameter int PW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [W-1:0]  multiplicand,
    input logic [W-1:0]  multiplier,
    input logic [PW-1:0] product,
    input logic          overflow,
    input logic          done,
    input logic          run
);
    localparam int CW = $clog2(W + 2) + 1;

    logic [2*PW-1:0] model;
    logic [CW-1:0]   pend;
    logic            accept;
    logic [CW-1:0]   lat;

    // Acceptance and expected latency derived from the operands.
    always_comb begin
        accept = start && !run;
        if (multiplicand == '0 || multiplier == '0) lat = CW'(1);
        else                                        lat = CW'($countones(multiplier));
    end

    // Reference product and countdown to the due completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            model <= '0;
            pend  <= '0;
        end else if (accept) begin
            model <= (2*PW)'(multiplicand) * (2*PW)'(multiplier);
            pend  <= lat;
        end else if (pend != '0) begin
            pend <= pend - 1'b1;
        end
    end

    p_result_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> product == model[PW-1:0]);

    p_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> overflow == (|model[2*PW-1:PW]));

    p_done_due_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == CW'(1)) |-> done);

    p_done_only_due_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> pend == CW'(1));

    p_zero_fast_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !run && (multiplicand == '0 || multiplier == '0))
            |=> (done && product == '0 && !overflow));

    p_no_done_in_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> !done);

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(product) && $stable(overflow)));
endmodule

bind horner_mul hm_checker #(.W(W), .PW(PW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .multiplicand (multiplicand),
    .multiplier   (multiplier),
    .product      (product),
    .overflow     (overflow),
    .done         (done),
    .run          (run)
);

// File: tb/sim_horner_mul.sv
`timescale 1ns/1ps
module sim_horner_mul;
    localparam int W  = 16;
    localparam int PW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [W-1:0]  a = '0;
    logic [W-1:0]  b = '0;
    logic [PW-1:0] product;
    logic          overflow;
    logic          done;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    horner_mul #(.W(W), .PW(PW)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .multiplicand (a),
        .multiplier   (b),
        .product      (product),
        .overflow     (overflow),
        .done         (done)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Launch one operation, measure latency and check result against the reference.
    task automatic run_op(input logic [W-1:0] x, input logic [W-1:0] m, input string req);
        logic [31:0] ref_p;
        int exp_lat;
        int n;
        ref_p   = 32'(x) * 32'(m);
        exp_lat = (x == 0 || m == 0) ? 1 : $countones(m);
        @(negedge clk);
        a = x; b = m; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        n = 1;
        while (!done && n < 40) begin
            @(negedge clk);
            n++;
        end
        chk(n == exp_lat, {req, " R4 latency"}, n, exp_lat);
        chk(product == ref_p[PW-1:0], {req, " R2 product"}, product, ref_p[PW-1:0]);
        chk(overflow == (ref_p[31:16] != 0), {req, " R3 overflow"}, overflow, ref_p[31:16] != 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(product == 0 && !overflow && !done, "R1 during reset", {product, overflow, done}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(product == 0 && !overflow && !done, "R1 after reset", {product, overflow, done}, 0);
    endtask

    task automatic t_worked();
        run_op(16'd23, 16'd77, "23x77");
        chk(product == 16'd1771, "R2 23x77 value", product, 1771);
        run_op(16'd1000, 16'd65, "1000x65");
        run_op(16'h00FF, 16'h0101, "ff x 101");
    endtask

    task automatic t_overflow();
        run_op(16'hFFFF, 16'hFFFF, "max x max R3");
        run_op(16'd256, 16'd256, "256x256 R3");
        run_op(16'd255, 16'd257, "255x257 edge R3");
    endtask

    task automatic t_zero();
        run_op(16'd0, 16'hFFFF, "zero multiplicand R5");
        run_op(16'h1234, 16'd0, "zero multiplier R5");
    endtask

    task automatic t_single_bit();
        run_op(16'h0ABC, 16'h0001, "bit0 R8");
        run_op(16'h0003, 16'h4000, "bit14 R8");
        run_op(16'h0001, 16'h8000, "bit15 R8");
        run_op(16'h0002, 16'h8000, "bit15 lost R8");
    endtask

    // A start during a run, and one during its last cycle, must not disturb it.
    task automatic t_busy_start();
        int n;
        @(negedge clk);
        a = 16'd3; b = 16'hFFFF; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 1;
        repeat (3) begin @(negedge clk); n++; end
        a = 16'd7; b = 16'd0; start = 1'b1;
        @(negedge clk); n++;
        start = 1'b0;
        while (!done && n < 40) begin
            if (n == 15) begin a = 16'd9; b = 16'd5; start = 1'b1; end
            @(negedge clk);
            n++;
            start = 1'b0;
        end
        chk(n == 16, "R6 latency kept", n, 16);
        chk(product == 16'(3 * 32'hFFFF), "R6 result kept", product, 16'(3 * 32'hFFFF));
        chk(overflow == 1'b1, "R6 overflow kept", overflow, 1);
        @(negedge clk);
        chk(!done, "R6 final-cycle start dropped", done, 0);
    endtask

    task automatic t_hold();
        logic [PW-1:0] p;
        logic o;
        run_op(16'd300, 16'd300, "hold setup");
        p = product; o = overflow;
        a = 16'd1; b = 16'd1;
        repeat (5) @(negedge clk);
        chk(product == p && overflow == o && !done, "R7 outputs held", product, p);
    endtask

    task automatic t_random();
        for (int i = 0; i < 60; i++) begin
            logic [W-1:0] x;
            logic [W-1:0] m;
            x = 16'($urandom);
            m = 16'($urandom);
            if (i % 3 == 0) x = x & 16'h00FF;
            if (i % 4 == 0) m = m & 16'h00F3;
            run_op(x, m, "random R2 R3");
        end
    endtask

    initial begin
        #800000;
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_worked();
        t_overflow();
        t_zero();
        t_single_bit();
        t_busy_start();
        t_hold();
        t_random();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule